// File: doc/BRIEF.md
# Serial-Line Interrupt Vector Arbiter

This block gathers interrupt requests from a bank of up to 16 serial lines and turns them into two master requests toward the processor. Each line can hold three pending conditions: a character was received, a modem/dataset signal changed, or the transmitter became ready. The receive and dataset-change conditions are both served through the receive-side master request. Transmit requests are served through the transmit-side master request.

When the processor acknowledges one side, the block returns that side's interrupt vector in the same cycle. The vector belongs to the pending line with the smallest index. At the next clock edge the block retires that line's request. A line's vector is derived from a common base vector and the line number. The receive and dataset conditions share one vector slot per line, and the transmit slot sits 4 above it.

The number of active lines is set by an input. Request pulses on lines beyond that count are discarded.

Top module: `sline_irq_arb`

## Requirements
- R1: `rx_irq` is high in the cycle after a receive or dataset set pulse on an active line. It stays high for as long as any receive or dataset pending bit remains. Bit i of every set/clear vector refers to line i.
- R2: `tx_irq` is high in the cycle after a transmit set pulse on an active line. It stays high for as long as any transmit pending bit remains.
- R3: A clear pulse removes only the addressed pending bit. A master request stays high while any other bit of its side remains pending.
- R4: While `rx_ack` is high and a receive-side bit is pending, `ack_vec` equals `base_vec + 8*n`. Here n is the lowest-numbered line with a receive or dataset bit pending.
- R5: A served receive acknowledge clears both the receive and the dataset pending bit of the chosen line at the next edge. Other lines are left untouched.
- R6: While `tx_ack` is high (and `rx_ack` is low) and a transmit bit is pending, `ack_vec` equals `base_vec + 8*n + 4`. Here n is the lowest-numbered line with a transmit bit pending. That line's transmit bit clears at the next edge.
- R7: An acknowledge on a side with nothing pending drives `ack_vec` to 0 and changes no pending bit.
- R8: When a set pulse and a clear (a clear pulse or an acknowledge retirement) hit the same bit in one cycle, the bit stays pending.
- R9: Only lines below the active count are served. The count is clamped: 0 acts as 1, and values above 16 act as 16. Set pulses on inactive lines are ignored. Bits of lines that become inactive are dropped at the next edge.
- R10: When `rx_ack` and `tx_ack` are high together, only the receive side is served. The transmit pending bits are left unchanged.
- R11: After reset, no bit is pending, both master requests are low and `ack_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| num_lines | input | 5 | Active line count (clamped to 1..16) |
| base_vec | input | 9 | Base interrupt vector |
| rx_set | input | 16 | Per-line receive request set pulses |
| rx_clr | input | 16 | Per-line receive request clear pulses |
| ds_set | input | 16 | Per-line dataset-change request set pulses |
| ds_clr | input | 16 | Per-line dataset-change request clear pulses |
| tx_set | input | 16 | Per-line transmit request set pulses |
| tx_clr | input | 16 | Per-line transmit request clear pulses |
| rx_ack | input | 1 | Receive-side acknowledge strobe |
| tx_ack | input | 1 | Transmit-side acknowledge strobe |
| rx_irq | output | 1 | Receive-side master request |
| tx_irq | output | 1 | Transmit-side master request |
| ack_vec | output | 9 | Vector of the served line during an acknowledge, else 0 |

## Verification
Two collisions can fall in the same cycle. The first is a new request arriving on the line that an acknowledge is retiring, or a set and a clear arriving on the same bit. The bench drives both in one cycle and expects the line to stay pending and to be served again by a second acknowledge. The second is both acknowledge strobes in one cycle. The bench checks that the returned vector is the receive one, and that a later transmit acknowledge still finds its line pending with the vector offset by 4.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int unsigned SLOT_STRIDE = 8;
  localparam int unsigned XMIT_OFFSET = 4;

  function automatic int unsigned line_vector(int unsigned base, int unsigned line, bit xmit);
    return base + line * SLOT_STRIDE + (xmit ? XMIT_OFFSET : 0);
  endfunction

  function automatic int unsigned active_lines(int unsigned req, int unsigned max_lines);
    if (req == 0) return 1;
    if (req > max_lines) return max_lines;
    return req;
  endfunction
endpackage

// File: rtl/irqarb_pend.sv
module irqarb_pend #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] pend_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign pend_d[g] = en_i[g] & (set_i[g] | (pend_q[g] & ~clr_i[g] & ~ack_clr_i[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & en_i)) |=> ((pend_q & $past(set_i & en_i)) == $past(set_i & en_i))); // R8

  AST_INACTIVE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(en_i)) == '0)); // R9
endmodule

// File: rtl/irqarb_pick.sv
module irqarb_pick #(
  parameter int N  = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [LW-1:0] idx_o,
  output logic [N-1:0]  gnt_o
);
  assign any_o = |req_i;
  assign gnt_o = req_i & (~req_i + N'(1));

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = LW'(i);
    end
  end

  AST_PICK_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ($onehot(gnt_o) && gnt_o[idx_o] && req_i[idx_o])); // R4
endmodule

// File: rtl/sline_irq_arb.sv
module sline_irq_arb #(
  parameter int MAX_LINES = 16,
  parameter int VEC_W     = 9,
  localparam int LW       = $clog2(MAX_LINES),
  localparam int CW       = LW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        num_lines,
  input  logic [VEC_W-1:0]     base_vec,
  input  logic [MAX_LINES-1:0] rx_set,
  input  logic [MAX_LINES-1:0] rx_clr,
  input  logic [MAX_LINES-1:0] ds_set,
  input  logic [MAX_LINES-1:0] ds_clr,
  input  logic [MAX_LINES-1:0] tx_set,
  input  logic [MAX_LINES-1:0] tx_clr,
  input  logic                 rx_ack,
  input  logic                 tx_ack,
  output logic                 rx_irq,
  output logic                 tx_irq,
  output logic [VEC_W-1:0]     ack_vec
);
  import irqarb_pkg::*;

  int unsigned          n_act;
  logic [MAX_LINES-1:0] en;
  logic [MAX_LINES-1:0] rx_pend, ds_pend, tx_pend, rx_req;
  logic [MAX_LINES-1:0] rx_gnt, tx_gnt, rx_ack_clr, tx_ack_clr;
  logic [LW-1:0]        rx_idx, tx_idx;
  logic                 rx_any, tx_any, rx_take, tx_take;

  assign n_act = active_lines(32'(num_lines), MAX_LINES);

  for (genvar g = 0; g < MAX_LINES; g++) begin : g_en
    assign en[g] = (g < n_act);
  end

  irqarb_pend #(.N(MAX_LINES)) u_rx_pend (
    .clk(clk), .rst_n(rst_n), .en_i(en), .set_i(rx_set), .clr_i(rx_clr),
    .ack_clr_i(rx_ack_clr), .pend_q(rx_pend));
  irqarb_pend #(.N(MAX_LINES)) u_ds_pend (
    .clk(clk), .rst_n(rst_n), .en_i(en), .set_i(ds_set), .clr_i(ds_clr),
    .ack_clr_i(rx_ack_clr), .pend_q(ds_pend));
  irqarb_pend #(.N(MAX_LINES)) u_tx_pend (
    .clk(clk), .rst_n(rst_n), .en_i(en), .set_i(tx_set), .clr_i(tx_clr),
    .ack_clr_i(tx_ack_clr), .pend_q(tx_pend));

  assign rx_req = rx_pend | ds_pend;

  irqarb_pick #(.N(MAX_LINES), .LW(LW)) u_rx_pick (
    .clk(clk), .rst_n(rst_n), .req_i(rx_req), .any_o(rx_any), .idx_o(rx_idx), .gnt_o(rx_gnt));
  irqarb_pick #(.N(MAX_LINES), .LW(LW)) u_tx_pick (
    .clk(clk), .rst_n(rst_n), .req_i(tx_pend), .any_o(tx_any), .idx_o(tx_idx), .gnt_o(tx_gnt));

  // Receive acknowledge has precedence over a simultaneous transmit acknowledge.
  assign rx_take    = rx_ack & rx_any;
  assign tx_take    = tx_ack & ~rx_ack & tx_any;
  assign rx_ack_clr = rx_take ? rx_gnt : '0;
  assign tx_ack_clr = tx_take ? tx_gnt : '0;

  assign rx_irq = rx_any;
  assign tx_irq = tx_any;

  always_comb begin
    ack_vec = '0;
    if (rx_take)      ack_vec = VEC_W'(line_vector(32'(base_vec), 32'(rx_idx), 1'b0));
    else if (tx_take) ack_vec = VEC_W'(line_vector(32'(base_vec), 32'(tx_idx), 1'b1));
  end

  AST_RX_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|((rx_set | ds_set) & en)) |=> rx_irq); // R1
  AST_TX_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tx_set & en)) |=> tx_irq); // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !rx_ack && rx_clr == '0 && ds_clr == '0 && $stable(en)) |=> rx_irq); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && !rx_set[rx_idx] && !ds_set[rx_idx])
      |=> (!rx_pend[$past(rx_idx)] && !ds_pend[$past(rx_idx)])); // R5
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !rx_irq) |-> (ack_vec == '0)); // R7
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && tx_ack && tx_clr == '0 && $stable(en))
      |=> ((tx_pend & $past(tx_pend)) == $past(tx_pend))); // R10
endmodule

// File: tb/tb_sline_irq_arb.sv
`timescale 1ns/1ps
module tb_sline_irq_arb;
  localparam int BASE = 'o300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  num_lines = 5'd16;
  logic [8:0]  base_vec = 9'(BASE);
  logic [15:0] rx_set = '0, rx_clr = '0, ds_set = '0, ds_clr = '0, tx_set = '0, tx_clr = '0;
  logic        rx_ack = 1'b0, tx_ack = 1'b0;
  logic        rx_irq, tx_irq;
  logic [8:0]  ack_vec;

  int total = 0;
  int fails = 0;
  int seen_vec = 0;

  always #4 clk = ~clk;

  sline_irq_arb dut (
    .clk(clk), .rst_n(rst_n), .num_lines(num_lines), .base_vec(base_vec),
    .rx_set(rx_set), .rx_clr(rx_clr), .ds_set(ds_set), .ds_clr(ds_clr),
    .tx_set(tx_set), .tx_clr(tx_clr), .rx_ack(rx_ack), .tx_ack(tx_ack),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .ack_vec(ack_vec));

  function automatic int exp_vec(int line, bit xmit);
    return BASE + (line << 3) + (xmit ? 4 : 0);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One-cycle stimulus; ack_vec is captured before the edge that consumes it.
  task automatic apply(logic [15:0] rs, logic [15:0] ds, logic [15:0] ts,
                       logic [15:0] rc, logic [15:0] dc, logic [15:0] tc,
                       logic ra, logic ta);
    @(negedge clk);
    rx_set = rs; ds_set = ds; tx_set = ts;
    rx_clr = rc; ds_clr = dc; tx_clr = tc;
    rx_ack = ra; tx_ack = ta;
    #1 seen_vec = int'(ack_vec);
    @(negedge clk);
    rx_set = '0; ds_set = '0; tx_set = '0;
    rx_clr = '0; ds_clr = '0; tx_clr = '0;
    rx_ack = 1'b0; tx_ack = 1'b0;
  endtask

  task automatic ack_rx(string req, int exp);
    apply('0, '0, '0, '0, '0, '0, 1'b1, 1'b0);
    check(seen_vec == exp, req, seen_vec, exp);
  endtask

  task automatic ack_tx(string req, int exp);
    apply('0, '0, '0, '0, '0, '0, 1'b0, 1'b1);
    check(seen_vec == exp, req, seen_vec, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(rx_irq == 1'b0, "R11", int'(rx_irq), 0);
    check(tx_irq == 1'b0, "R11", int'(tx_irq), 0);
    check(ack_vec == '0, "R11", int'(ack_vec), 0);

    // Sweep every line with each request kind (R1, R2, R4, R5, R6)
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 3; k++) begin
        logic [15:0] b;
        b = 16'(1) << i;
        if (k == 0) apply(b, '0, '0, '0, '0, '0, 1'b0, 1'b0);
        if (k == 1) apply('0, b, '0, '0, '0, '0, 1'b0, 1'b0);
        if (k == 2) apply('0, '0, b, '0, '0, '0, 1'b0, 1'b0);
        if (k < 2) begin
          check(rx_irq == 1'b1, "R1", int'(rx_irq), 1);
          ack_rx("R4", exp_vec(i, 1'b0));
          check(rx_irq == 1'b0, "R5", int'(rx_irq), 0);
        end else begin
          check(tx_irq == 1'b1, "R2", int'(tx_irq), 1);
          ack_tx("R6", exp_vec(i, 1'b1));
          check(tx_irq == 1'b0, "R6", int'(tx_irq), 0);
        end
      end
    end

    // Fixed priority drain over multi-line patterns (R4, R6)
    begin
      logic [15:0] rp, tp;
      rp = 16'hA4C0; tp = 16'h0132;
      apply(rp, '0, tp, '0, '0, '0, 1'b0, 1'b0);
      while (rp != 0) begin
        int lo;
        lo = 0;
        while (!rp[lo]) lo++;
        ack_rx("R4", exp_vec(lo, 1'b0));
        rp[lo] = 1'b0;
      end
      check(rx_irq == 1'b0, "R4", int'(rx_irq), 0);
      while (tp != 0) begin
        int lo;
        lo = 0;
        while (!tp[lo]) lo++;
        ack_tx("R6", exp_vec(lo, 1'b1));
        tp[lo] = 1'b0;
      end
      check(tx_irq == 1'b0, "R6", int'(tx_irq), 0);
    end

    // R3 clear pulse removes one bit, master stays up
    apply(16'h0088, '0, 16'h0001, '0, '0, '0, 1'b0, 1'b0);
    apply('0, '0, '0, 16'h0008, '0, 16'h0001, 1'b0, 1'b0);
    check(rx_irq == 1'b1, "R3", int'(rx_irq), 1);
    check(tx_irq == 1'b0, "R3", int'(tx_irq), 0);
    ack_rx("R3", exp_vec(7, 1'b0));
    check(rx_irq == 1'b0, "R3", int'(rx_irq), 0);

    // R5 receive acknowledge retires both bits of the chosen line
    apply(16'h0020, 16'h0220, '0, '0, '0, '0, 1'b0, 1'b0);
    ack_rx("R5", exp_vec(5, 1'b0));
    check(rx_irq == 1'b1, "R5", int'(rx_irq), 1);
    ack_rx("R5", exp_vec(9, 1'b0));
    check(rx_irq == 1'b0, "R5", int'(rx_irq), 0);

    // R7 acknowledge with nothing pending
    ack_rx("R7", 0);
    ack_tx("R7", 0);
    check(rx_irq == 1'b0 && tx_irq == 1'b0, "R7", int'({rx_irq, tx_irq}), 0);
    apply(16'h0010, '0, '0, '0, '0, '0, 1'b0, 1'b0);
    ack_tx("R7", 0);
    check(rx_irq == 1'b1, "R7", int'(rx_irq), 1);
    ack_rx("R7", exp_vec(4, 1'b0));

    // R8 set coinciding with acknowledge retirement, and with a clear pulse
    apply(16'h0004, '0, '0, '0, '0, '0, 1'b0, 1'b0);
    apply(16'h0004, '0, '0, '0, '0, '0, 1'b1, 1'b0);
    check(seen_vec == exp_vec(2, 1'b0), "R8", seen_vec, exp_vec(2, 1'b0));
    check(rx_irq == 1'b1, "R8", int'(rx_irq), 1);
    ack_rx("R8", exp_vec(2, 1'b0));
    apply(16'h0040, '0, 16'h0800, 16'h0040, '0, 16'h0800, 1'b0, 1'b0);
    check(rx_irq == 1'b1 && tx_irq == 1'b1, "R8", int'({rx_irq, tx_irq}), 3);
    ack_rx("R8", exp_vec(6, 1'b0));
    ack_tx("R8", exp_vec(11, 1'b1));

    // R10 both acknowledges together
    apply(16'h0002, '0, 16'h0008, '0, '0, '0, 1'b0, 1'b0);
    apply('0, '0, '0, '0, '0, '0, 1'b1, 1'b1);
    check(seen_vec == exp_vec(1, 1'b0), "R10", seen_vec, exp_vec(1, 1'b0));
    check(rx_irq == 1'b0, "R10", int'(rx_irq), 0);
    check(tx_irq == 1'b1, "R10", int'(tx_irq), 1);
    ack_tx("R10", exp_vec(3, 1'b1));

    // R9 active line count
    @(negedge clk) num_lines = 5'd4;
    apply(16'h0400, '0, 16'h0008, '0, '0, '0, 1'b0, 1'b0);
    check(rx_irq == 1'b0, "R9", int'(rx_irq), 0);
    ack_tx("R9", exp_vec(3, 1'b1));
    @(negedge clk) num_lines = 5'd0;
    apply(16'h0003, '0, '0, '0, '0, '0, 1'b0, 1'b0);
    ack_rx("R9", exp_vec(0, 1'b0));
    check(rx_irq == 1'b0, "R9", int'(rx_irq), 0);
    @(negedge clk) num_lines = 5'd20;
    apply(16'h8000, '0, '0, '0, '0, '0, 1'b0, 1'b0);
    ack_rx("R9", exp_vec(15, 1'b0));
    @(negedge clk) num_lines = 5'd16;
    apply('0, 16'h1000, '0, '0, '0, '0, 1'b0, 1'b0);
    check(rx_irq == 1'b1, "R9", int'(rx_irq), 1);
    @(negedge clk) num_lines = 5'd8;
    @(negedge clk);
    check(rx_irq == 1'b0, "R9", int'(rx_irq), 0);

    summary();
  end
endmodule